// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block decides which of four DMA channels is served next and runs one single transfer for it. A single transfer is a read access followed by a write access. Each channel presents a request line and two 3-bit region codes, one for its source and one for its destination. The region code sets how many clocks the matching access lasts. A shared wait count stretches peripheral-register accesses. A ready input ends accesses to external memory.

The block models each access as a strobe held for the access length: a read strobe, then a write strobe. It does not model addresses or data. When the write ends, the block pulses a one-hot done flag for the channel and clears the request it had captured for that channel. Two outputs show the channel being served and the current engine phase, so a surrounding datapath can follow each transfer.

The arbiter chooses a channel again before every single transfer, with fixed priority. A channel that asks while another channel is mid-transfer is therefore ranked against every request still waiting as soon as that transfer ends.

Top module: `dma_xfer_seq`

## Requirements
- R1: When several captured requests wait at an arbitration point, the lowest-numbered channel is served first. Channel 0 has the highest priority and channel 3 the lowest. active_ch_o shows the served channel as a 2-bit index.
- R2: Arbitration happens again before each single transfer. A request that arrives during a lower channel's transfer is served before any lower channel still waiting.
- R3: With the engine idle, rd_strobe_o first goes high on the fourth rising edge after the edge that captures the request.
- R4: After every read access, exactly one clock passes with both strobes low before the write strobe rises. rd_strobe_o and wr_strobe_o are never high together.
- R5: Region code 0 (internal RAM) and the unused codes 5, 6 and 7 give a 2-clock access. Code 2 (USB registers) and code 3 (data-only RAM) give a 4-clock access.
- R6: Region code 1 (peripheral registers) gives an access of 3 + periph_wait_i clocks.
- R7: Region code 4 (external memory) lasts at least 2 clocks. The access ends on the first of its clocks, from the second onward, in which ext_ready_i is high.
- R8: In the clock after the last write clock, done_o pulses for exactly one clock with only bit c set, where c is the served channel. That channel's captured request is then cleared, so the channel gets no further transfer without a new request.
- R9: An active-low asynchronous reset returns the engine to idle and clears all captured requests. Both strobes and done_o are low, and nothing runs until a new request arrives.
- R10: phase_o reports the engine phase: 0 idle, 1 response wait, 2 read, 3 idle gap, 4 write, 5 done. active_ch_o stays steady from the response wait through the done clock.
- R11: If a channel's request line is high in the same clock as that channel's done pulse, the request is kept and causes a further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel request lines, captured on each rising edge |
| src_region_i | input | 12 | Source region code of channel c at bits [3c+2:3c] |
| dst_region_i | input | 12 | Destination region code of channel c at bits [3c+2:3c] |
| periph_wait_i | input | 4 | Extra wait clocks for peripheral-register accesses |
| ext_ready_i | input | 1 | Ends an external-memory access (from its second clock onward) |
| rd_strobe_o | output | 1 | High for each clock of the read access |
| wr_strobe_o | output | 1 | High for each clock of the write access |
| done_o | output | 4 | One-clock, one-hot completion pulse per channel |
| active_ch_o | output | 2 | Index of the channel being served |
| phase_o | output | 3 | Engine phase code (see R10) |

## Verification
Two events can fall in the same clock. The first is a channel's done pulse, which clears its captured request. The second is a new request edge on that same channel, which sets it. The bench watches for done_o of channel 1 and raises req_i[1] in that same cycle. It passes only if a second full channel-1 transfer follows. Arbitration can also coincide with a higher channel arriving mid-transfer. The bench provokes this by pulsing channel 0 while channel 2 reads with channel 3 still waiting, then checks that the done order is 2, 0, 3.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RESP  = 3'd1,
    PH_READ  = 3'd2,
    PH_GAP   = 3'd3,
    PH_WRITE = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  localparam int unsigned REG_W = 3;
  localparam logic [REG_W-1:0] RG_IRAM = 3'd0;
  localparam logic [REG_W-1:0] RG_PERI = 3'd1;
  localparam logic [REG_W-1:0] RG_USB  = 3'd2;
  localparam logic [REG_W-1:0] RG_DRAM = 3'd3;
  localparam logic [REG_W-1:0] RG_EXT  = 3'd4;

  localparam int unsigned LEN_W     = 8;
  localparam int unsigned RAM_CLKS  = 2;
  localparam int unsigned PERI_BASE = 3;
  localparam int unsigned SLOW_CLKS = 4;
  localparam int unsigned EXT_MIN   = 2;

  typedef struct packed {
    logic             is_ext;
    logic [LEN_W-1:0] clks;
  } acc_cfg_t;

endpackage

// File: rtl/dma_req_latch.sv
`timescale 1ns/1ps
module dma_req_latch #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] pend_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pend_q;

    // a new request in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (req_i[c]) pend_q <= 1'b1;
      else if (clr_i[c]) pend_q <= 1'b0;
    end

    assign pend_o[c] = pend_q;

    p_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[c] |=> pend_o[c]);
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !req_i[c]) |=> !pend_o[c]);
  end

endmodule

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
module dma_prio_arb #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned IDX_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   pend_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  logic [NCH-1:0] lower_mask;
  assign lower_mask = (NCH'(1) << idx_o) - NCH'(1);

  p_prio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && ((pend_i & lower_mask) == '0)));
  p_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != '0) |-> valid_o);

endmodule

// File: rtl/dma_region_decode.sv
`timescale 1ns/1ps
module dma_region_decode
  import dma_seq_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic [REG_W-1:0]  code_i,
  input  logic [WAIT_W-1:0] wait_i,
  output acc_cfg_t          cfg_o
);

  always_comb begin
    cfg_o.is_ext = 1'b0;
    cfg_o.clks   = LEN_W'(RAM_CLKS);
    case (code_i)
      RG_PERI:          cfg_o.clks = LEN_W'(PERI_BASE) + LEN_W'(wait_i);
      RG_USB, RG_DRAM:  cfg_o.clks = LEN_W'(SLOW_CLKS);
      RG_EXT: begin
        cfg_o.is_ext = 1'b1;
        cfg_o.clks   = LEN_W'(EXT_MIN);
      end
      default:          cfg_o.clks = LEN_W'(RAM_CLKS);
    endcase
  end

endmodule

// File: rtl/dma_access_timer.sv
`timescale 1ns/1ps
module dma_access_timer
  import dma_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  acc_cfg_t cfg_i,
  input  logic     ext_ready_i,
  output logic     last_o
);

  logic [LEN_W-1:0] cnt_q;
  logic             len_met;

  assign len_met = (cnt_q + LEN_W'(1)) >= cfg_i.clks;
  assign last_o  = run_i && len_met && (!cfg_i.is_ext || ext_ready_i);

  // counter holds once length is met (external waits on ready)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || last_o) cnt_q <= '0;
    else if (!len_met)        cnt_q <= cnt_q + LEN_W'(1);
  end

  p_min_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !last_o);
  p_ext_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_i.is_ext && !ext_ready_i) |-> !last_o);

endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned WAIT_W    = 4,
  parameter int unsigned RESP_CLKS = 4,
  localparam int unsigned IDX_W    = $clog2(NCH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     req_i,
  input  logic [NCH*REG_W-1:0] src_region_i,
  input  logic [NCH*REG_W-1:0] dst_region_i,
  input  logic [WAIT_W-1:0]  periph_wait_i,
  input  logic               ext_ready_i,
  output logic               rd_strobe_o,
  output logic               wr_strobe_o,
  output logic [NCH-1:0]     done_o,
  output logic [IDX_W-1:0]   active_ch_o,
  output logic [2:0]         phase_o
);

  localparam int unsigned RESP_CW = (RESP_CLKS > 2) ? $clog2(RESP_CLKS - 1) : 1;
  localparam logic [RESP_CW-1:0] RESP_LAST = RESP_CW'(RESP_CLKS - 2);

  phase_e             phase_q, phase_d;
  logic [IDX_W-1:0]   chan_q;
  logic [RESP_CW-1:0] resp_cnt_q;
  logic [NCH-1:0]     pend;
  logic               arb_valid;
  logic [IDX_W-1:0]   arb_idx;
  logic [REG_W-1:0]   src_code, dst_code;
  acc_cfg_t           src_cfg, dst_cfg, acc_cfg;
  logic               acc_run, acc_last;

  dma_req_latch #(.NCH(NCH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (done_o),
    .pend_o (pend)
  );

  dma_prio_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  assign src_code = src_region_i[chan_q*REG_W +: REG_W];
  assign dst_code = dst_region_i[chan_q*REG_W +: REG_W];

  dma_region_decode #(.WAIT_W(WAIT_W)) u_src_dec (
    .code_i (src_code),
    .wait_i (periph_wait_i),
    .cfg_o  (src_cfg)
  );

  dma_region_decode #(.WAIT_W(WAIT_W)) u_dst_dec (
    .code_i (dst_code),
    .wait_i (periph_wait_i),
    .cfg_o  (dst_cfg)
  );

  assign acc_run = (phase_q == PH_READ) || (phase_q == PH_WRITE);
  assign acc_cfg = (phase_q == PH_READ) ? src_cfg : dst_cfg;

  dma_access_timer u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (acc_run),
    .cfg_i       (acc_cfg),
    .ext_ready_i (ext_ready_i),
    .last_o      (acc_last)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (arb_valid) phase_d = PH_RESP;
      PH_RESP:  if (resp_cnt_q == RESP_LAST) phase_d = PH_READ;
      PH_READ:  if (acc_last) phase_d = PH_GAP;
      PH_GAP:   phase_d = PH_WRITE;
      PH_WRITE: if (acc_last) phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      chan_q     <= '0;
      resp_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_IDLE && arb_valid) begin
        chan_q     <= arb_idx;
        resp_cnt_q <= '0;
      end else if (phase_q == PH_RESP) begin
        resp_cnt_q <= resp_cnt_q + RESP_CW'(1);
      end
    end
  end

  assign rd_strobe_o = (phase_q == PH_READ);
  assign wr_strobe_o = (phase_q == PH_WRITE);
  assign done_o      = (phase_q == PH_DONE) ? (NCH'(1) << chan_q) : '0;
  assign active_ch_o = chan_q;
  assign phase_o     = phase_q;

  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_o && wr_strobe_o));
  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_strobe_o) |-> (phase_o == PH_GAP && !wr_strobe_o));
  p_gap_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_GAP) |=> wr_strobe_o);
  p_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_strobe_o) |-> ($past(phase_o) == PH_RESP));
  p_done_hot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
  p_done_after_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_strobe_o) |-> (done_o != '0));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |=> (done_o == '0));
  p_chan_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != PH_IDLE && $past(phase_o) != PH_IDLE) |-> $stable(active_ch_o));

endmodule

// File: tb/dma_xfer_seq_tb.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  req_i = '0;
  logic [11:0] src_region_i = '0;
  logic [11:0] dst_region_i = '0;
  logic [3:0]  periph_wait_i = '0;
  logic        ext_ready_i = 1'b0;
  logic        rd_strobe_o, wr_strobe_o;
  logic [3:0]  done_o;
  logic [1:0]  active_ch_o;
  logic [2:0]  phase_o;

  int n_chk = 0;
  int n_err = 0;
  int ext_lat = 1;
  int acc_cnt = 0;

  always #2.5 clk = ~clk;

  dma_xfer_seq u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .src_region_i  (src_region_i),
    .dst_region_i  (dst_region_i),
    .periph_wait_i (periph_wait_i),
    .ext_ready_i   (ext_ready_i),
    .rd_strobe_o   (rd_strobe_o),
    .wr_strobe_o   (wr_strobe_o),
    .done_o        (done_o),
    .active_ch_o   (active_ch_o),
    .phase_o       (phase_o)
  );

  // external-memory model: ready from access clock ext_lat onward
  always @(negedge clk) begin
    if (rd_strobe_o || wr_strobe_o) acc_cnt = acc_cnt + 1;
    else acc_cnt = 0;
    ext_ready_i = (acc_cnt != 0) && (acc_cnt >= ext_lat);
  end

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int code, input int wt, input int lat);
    case (code)
      1: return 3 + wt;
      2, 3: return 4;
      4: return (lat > 2) ? lat : 2;
      default: return 2;
    endcase
  endfunction

  function automatic string len_tag(input int code);
    if (code == 1) return "R6";
    if (code == 4) return "R7";
    return "R5";
  endfunction

  function automatic int hot_idx(input logic [3:0] v);
    int idx = -2;
    if ($countones(v) == 1) for (int i = 0; i < NCH; i++) if (v[i]) idx = i;
    return idx;
  endfunction

  task automatic set_regions(input int ch, input int src, input int dst);
    src_region_i[ch*3 +: 3] = 3'(src);
    dst_region_i[ch*3 +: 3] = 3'(dst);
  endtask

  task automatic pulse_req(input logic [3:0] mask);
    @(negedge clk);
    req_i = mask;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic observe(output int t_rd, output int n_rd, output int n_gap,
                         output int n_wr, output int done_ch, output int ph_ok);
    int i = 1;
    t_rd = -1; n_rd = 0; n_gap = 0; n_wr = 0; done_ch = -1; ph_ok = 1;
    while (i < 400) begin
      if (rd_strobe_o) begin
        if (t_rd < 0) t_rd = i;
        n_rd++;
        if (phase_o != 3'd2) ph_ok = 0;
      end
      if (phase_o == 3'd3) begin
        n_gap++;
        if (rd_strobe_o || wr_strobe_o) ph_ok = 0;
      end
      if (wr_strobe_o) begin
        n_wr++;
        if (phase_o != 3'd4) ph_ok = 0;
      end
      if (done_o != '0) begin
        done_ch = hot_idx(done_o);
        if (phase_o != 3'd5) ph_ok = 0;
        break;
      end
      @(negedge clk);
      i++;
    end
  endtask

  task automatic wait_done(output int ch);
    int i = 0;
    ch = -1;
    while (i < 400 && done_o == '0) begin
      @(negedge clk);
      i++;
    end
    if (done_o != '0) ch = hot_idx(done_o);
    @(negedge clk);
  endtask

  task automatic quiet(input string rq, input int cycles);
    int busy = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (phase_o != 3'd0 || rd_strobe_o || wr_strobe_o || done_o != '0) busy++;
    end
    check(rq, "no activity without new request", busy, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    req_i  = '0;
    repeat (3) @(negedge clk);
    check("R9", "phase in reset", phase_o, 0);
    check("R9", "strobes/done in reset", {rd_strobe_o, wr_strobe_o, done_o}, 0);
    rst_ni = 1'b1;
    quiet("R9", 10);
  endtask

  task automatic t_single(input int ch, input int src, input int dst,
                          input int wt, input int lat);
    int t_rd, n_rd, n_gap, n_wr, dch, ph_ok;
    set_regions(ch, src, dst);
    periph_wait_i = 4'(wt);
    ext_lat = lat;
    pulse_req(4'(1 << ch));
    observe(t_rd, n_rd, n_gap, n_wr, dch, ph_ok);
    check("R3", "read start delay", t_rd, 5);
    check(len_tag(src), "read length", n_rd, exp_len(src, wt, lat));
    check("R4", "gap clocks", n_gap, 1);
    check(len_tag(dst), "write length", n_wr, exp_len(dst, wt, lat));
    check("R8", "done channel", dch, ch);
    check("R10", "phase codes", ph_ok, 1);
    check("R10", "active channel", active_ch_o, ch);
    @(negedge clk);
    check("R8", "done width", done_o, 0);
    quiet("R8", 12);
  endtask

  task automatic t_priority();
    int ch;
    for (int c = 0; c < NCH; c++) set_regions(c, 0, 0);
    pulse_req(4'hF);
    for (int k = 0; k < NCH; k++) begin
      wait_done(ch);
      check("R1", "service order", ch, k);
    end
    quiet("R8", 12);
  endtask

  task automatic t_takeover();
    int ch;
    int i = 0;
    set_regions(0, 0, 0);
    set_regions(2, 2, 2);
    set_regions(3, 0, 0);
    pulse_req(4'b1100);
    while (!rd_strobe_o && i < 50) begin
      @(negedge clk);
      i++;
    end
    check("R1", "first granted", active_ch_o, 2);
    pulse_req(4'b0001);
    wait_done(ch);
    check("R2", "order slot 0", ch, 2);
    wait_done(ch);
    check("R2", "order slot 1", ch, 0);
    wait_done(ch);
    check("R2", "order slot 2", ch, 3);
    quiet("R8", 12);
  endtask

  task automatic t_req_at_done();
    int ch;
    int i = 0;
    set_regions(1, 0, 3);
    pulse_req(4'b0010);
    while (done_o == '0 && i < 100) begin
      @(negedge clk);
      i++;
    end
    check("R11", "first done", hot_idx(done_o), 1);
    req_i = 4'b0010;
    @(negedge clk);
    req_i = '0;
    wait_done(ch);
    check("R11", "kept request served", ch, 1);
    quiet("R11", 12);
  endtask

  task automatic t_reset_mid();
    int i = 0;
    set_regions(0, 2, 2);
    set_regions(2, 0, 0);
    pulse_req(4'b0101);
    while (!rd_strobe_o && i < 50) begin
      @(negedge clk);
      i++;
    end
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "phase during mid reset", phase_o, 0);
    rst_ni = 1'b1;
    quiet("R9", 15);
  endtask

  task automatic run_all();
    t_reset();
    t_single(0, 0, 2, 0, 1);
    t_single(1, 3, 1, 0, 1);
    t_single(2, 1, 5, 3, 1);
    t_single(3, 7, 4, 0, 1);
    t_single(0, 4, 6, 0, 4);
    t_single(1, 4, 1, 9, 6);
    t_priority();
    t_takeover();
    t_req_at_done();
    t_reset_mid();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule